// File: doc/BRIEF.md
# Protected Register Slave with Privilege and Alignment Screening

This block is an AHB-Lite slave in front of a small bank of 32-bit control and status words. Each transfer is screened in its address phase. The transfer must be a single word. Its privilege level, taken from HPROT bit 1, must match the mode set on a configuration pin. It must reach a populated word. When the alignment check is switched on, its byte offset must also be zero. A transfer that passes is served with no wait states. A transfer that fails gets the standard two-cycle ERROR response, and it never changes a register.

The bank holds an enable word, a status word, and a parameterised number of read/write scratch words. A hardware event input sets bits in the status word, and software clears them by writing ones. All register contents are driven onto output ports so that neighbouring logic can use them directly.

Top module: `prs_reg_slave`

## Requirements
- R1: After reset, HREADYOUT is 1, HRESP is 0 (OKAY), and the enable, status and scratch registers are all zero.
- R2: A legal write updates its register at the end of the data phase. Word index = HADDR[7:2]: 0 is enable, 1 is status, 2 and 3 are scratch 0 and 1. A legal read returns the addressed word on HRDATA in its data phase.
- R3: A status bit is set by a one on the matching status_set_i bit. A legal write to index 1 clears every bit written as one and leaves every bit written as zero unchanged.
- R4: With priv_only_i=1, only transfers with HPROT[1]=1 are legal. With priv_only_i=0, only transfers with HPROT[1]=0 are legal. A mismatch gets an ERROR response, and its write changes no register.
- R5: A NONSEQ or SEQ transfer with HSIZE other than 3'b010 (word) gets an ERROR response and changes no register.
- R6: With align_chk_i=1, a transfer with HADDR[1:0] not zero gets an ERROR response. With align_chk_i=0, the low two address bits are ignored and the word at HADDR[7:2] is accessed.
- R7: A transfer to a word index of 4 or more gets an ERROR response and changes no register.
- R8: An ERROR response lasts exactly two cycles. The first cycle has HRESP=1 and HREADYOUT=0. The second has HRESP=1 and HREADYOUT=1. The following cycle is OKAY unless a new illegal transfer was accepted.
- R9: IDLE (HTRANS=00) and BUSY (HTRANS=01) transfers, and any transfer with HSEL low, get a zero-wait OKAY response and change no register.
- R10: Whenever HRESP is OKAY, HREADYOUT is 1: legal transfers insert no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| haddr | input | 8 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size, only 3'b010 is legal |
| hprot | input | 4 | Protection attributes, bit 1 is privilege |
| hwdata | input | 32 | Write data, valid in the data phase |
| priv_only_i | input | 1 | 1 = privileged accesses only, 0 = user accesses only |
| align_chk_i | input | 1 | 1 = reject transfers whose address is not word aligned |
| status_set_i | input | 32 | Per-bit set pulses into the status word |
| hrdata | output | 32 | Read data, zero outside a legal read data phase |
| hreadyout | output | 1 | Transfer done / slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| ctrl_en_o | output | 32 | Enable register contents |
| status_o | output | 32 | Status register contents |
| scratch_o | output | 64 | Scratch registers, word k in bits [32k+31:32k] |

## Verification
The assertions assume the master follows AHB-Lite. An address phase is presented only while HREADYOUT is high, and the master does not drive a new address phase during the first ERROR cycle. They also assume status_set_i never sets a bit in the same cycle that software clears it. The stimulus keeps to these assumptions. Every transfer is non-pipelined: its address phase is followed by IDLE until the response completes. Event pulses on status_set_i are issued only between transfers.

// File: rtl/prs_pkg.sv
package prs_pkg;

   localparam logic [1:0] TR_IDLE   = 2'b00;
   localparam logic [1:0] TR_BUSY   = 2'b01;
   localparam logic [1:0] TR_NONSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ    = 2'b11;

   localparam logic [2:0] SZ_WORD       = 3'b010;
   localparam int         PROT_PRIV_BIT = 1;

   localparam int IDX_CTRL   = 0;
   localparam int IDX_STATUS = 1;
   localparam int IDX_SCR0   = 2;

   typedef enum logic [1:0] {
      RSP_OKAY     = 2'b00,
      RSP_ERR_WAIT = 2'b01,
      RSP_ERR_DONE = 2'b10
   } rsp_state_e;

   typedef struct packed {
      logic size_bad;
      logic priv_bad;
      logic align_bad;
      logic map_bad;
   } acc_fault_t;

endpackage

// File: rtl/prs_access_check.sv
module prs_access_check
   import prs_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_REGS = 4,
   parameter int IDX_W    = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   input  logic [3:0]        prot,
   input  logic              priv_only,
   input  logic              align_chk,
   output logic              legal,
   output logic [IDX_W-1:0]  idx,
   output acc_fault_t        fault
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              mapped;
   logic              unused_prot;

   assign word        = addr[ADDR_W-1:2];
   assign idx         = word[IDX_W-1:0];
   assign unused_prot = ^{prot[3:2], prot[0]};

   generate
      if ((2 ** WORD_W) <= NUM_REGS) begin : g_full_map
         assign mapped = 1'b1;
      end else begin : g_part_map
         assign mapped = (int'(word) < NUM_REGS);
      end
   endgenerate

   always_comb begin
      fault.size_bad  = (size != SZ_WORD);
      fault.priv_bad  = (prot[PROT_PRIV_BIT] != priv_only);
      fault.align_bad = align_chk && (addr[1:0] != 2'b00);
      fault.map_bad   = !mapped;
      legal           = (fault == '0);
   end

endmodule

// File: rtl/prs_rsp_fsm.sv
module prs_rsp_fsm
   import prs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_start,
   input  logic xfer_legal,
   output logic hreadyout,
   output logic hresp
);

   rsp_state_e state_q, state_d;

   always_comb begin
      state_d = RSP_OKAY;
      case (state_q)
         RSP_ERR_WAIT: state_d = RSP_ERR_DONE;
         default:      state_d = (xfer_start && !xfer_legal) ? RSP_ERR_WAIT : RSP_OKAY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RSP_OKAY;
      else        state_q <= state_d;
   end

   assign hreadyout = (state_q != RSP_ERR_WAIT);
   assign hresp     = (state_q != RSP_OKAY);

endmodule

// File: rtl/prs_reg_bank.sv
module prs_reg_bank
   import prs_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NUM_SCRATCH = 2,
   parameter int IDX_W       = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [DATA_W-1:0]             set_bits,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [DATA_W-1:0]             rd_data,
   output logic [DATA_W-1:0]             ctrl_q,
   output logic [DATA_W-1:0]             stat_q,
   output logic [NUM_SCRATCH*DATA_W-1:0] scratch_flat
);

   localparam int NUM_REGS = 2 + NUM_SCRATCH;

   logic [DATA_W-1:0] words [NUM_REGS];
   logic [DATA_W-1:0] clr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     ctrl_q <= '0;
      else if (wr_en && int'(wr_idx) == IDX_CTRL)     ctrl_q <= wr_data;
   end

   assign clr_bits = (wr_en && int'(wr_idx) == IDX_STATUS) ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_bits) | set_bits;
   end

   assign words[IDX_CTRL]   = ctrl_q;
   assign words[IDX_STATUS] = stat_q;

   generate
      for (genvar k = 0; k < NUM_SCRATCH; k++) begin : g_scr
         logic [DATA_W-1:0] scr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      scr_q <= '0;
            else if (wr_en && int'(wr_idx) == IDX_SCR0 + k)  scr_q <= wr_data;
         end
         assign words[IDX_SCR0+k]               = scr_q;
         assign scratch_flat[k*DATA_W +: DATA_W] = scr_q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(rd_idx) == i) rd_data = words[i];
      end
   end

endmodule

// File: rtl/prs_reg_slave.sv
module prs_reg_slave
   import prs_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int NUM_SCRATCH = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          hsel,
   input  logic [ADDR_W-1:0]             haddr,
   input  logic [1:0]                    htrans,
   input  logic                          hwrite,
   input  logic [2:0]                    hsize,
   input  logic [3:0]                    hprot,
   input  logic [DATA_W-1:0]             hwdata,
   input  logic                          priv_only_i,
   input  logic                          align_chk_i,
   input  logic [DATA_W-1:0]             status_set_i,
   output logic [DATA_W-1:0]             hrdata,
   output logic                          hreadyout,
   output logic                          hresp,
   output logic [DATA_W-1:0]             ctrl_en_o,
   output logic [DATA_W-1:0]             status_o,
   output logic [NUM_SCRATCH*DATA_W-1:0] scratch_o
);

   localparam int NUM_REGS = 2 + NUM_SCRATCH;
   localparam int IDX_W    = $clog2(NUM_REGS);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("prs_reg_slave: only 32-bit data is supported");
      end
      if (NUM_SCRATCH < 1) begin : g_bad_scr
         $error("prs_reg_slave: NUM_SCRATCH must be at least 1");
      end
      if (ADDR_W < IDX_W + 2) begin : g_bad_addr
         $error("prs_reg_slave: ADDR_W too small for the register count");
      end
   endgenerate

   logic             addr_phase;
   logic             acc_legal;
   logic [IDX_W-1:0] acc_idx;
   acc_fault_t       acc_fault;
   logic             dp_wr_q, dp_rd_q;
   logic [IDX_W-1:0] dp_idx_q;
   logic [DATA_W-1:0] rd_word;
   logic             unused_sig;

   assign unused_sig = htrans[0] ^ (^acc_fault);
   assign addr_phase = hsel && htrans[1] && hreadyout;

   prs_access_check #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) u_check (
      .addr      (haddr),
      .size      (hsize),
      .prot      (hprot),
      .priv_only (priv_only_i),
      .align_chk (align_chk_i),
      .legal     (acc_legal),
      .idx       (acc_idx),
      .fault     (acc_fault)
   );

   prs_rsp_fsm u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_start (addr_phase),
      .xfer_legal (acc_legal),
      .hreadyout  (hreadyout),
      .hresp      (hresp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_wr_q  <= 1'b0;
         dp_rd_q  <= 1'b0;
         dp_idx_q <= '0;
      end else begin
         dp_wr_q  <= addr_phase && acc_legal && hwrite;
         dp_rd_q  <= addr_phase && acc_legal && !hwrite;
         if (addr_phase) dp_idx_q <= acc_idx;
      end
   end

   prs_reg_bank #(
      .DATA_W      (DATA_W),
      .NUM_SCRATCH (NUM_SCRATCH),
      .IDX_W       (IDX_W)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (dp_wr_q),
      .wr_idx       (dp_idx_q),
      .wr_data      (hwdata),
      .set_bits     (status_set_i),
      .rd_idx       (dp_idx_q),
      .rd_data      (rd_word),
      .ctrl_q       (ctrl_en_o),
      .stat_q       (status_o),
      .scratch_flat (scratch_o)
   );

   assign hrdata = dp_rd_q ? rd_word : '0;

endmodule

// File: rtl/prs_checker.sv
module prs_checker
   import prs_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int NUM_SCRATCH = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          hsel,
   input logic [ADDR_W-1:0]             haddr,
   input logic [1:0]                    htrans,
   input logic [2:0]                    hsize,
   input logic [3:0]                    hprot,
   input logic                          priv_only_i,
   input logic                          align_chk_i,
   input logic                          hreadyout,
   input logic                          hresp,
   input logic [DATA_W-1:0]             ctrl_en_o,
   input logic [NUM_SCRATCH*DATA_W-1:0] scratch_o
);

   localparam int NUM_REGS = 2 + NUM_SCRATCH;

   logic start, err_first, quiet;
   assign start     = hsel && htrans[1] && hreadyout;
   assign err_first = hresp && !hreadyout;
   assign quiet     = hreadyout && !(hsel && htrans[1]);

   AST_RESET_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> hreadyout && !hresp);                                 // R1
   AST_PRIV_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      start && (hprot[1] != priv_only_i) |=> err_first);                     // R4
   AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      start && (hsize != SZ_WORD) |=> err_first);                            // R5
   AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      start && align_chk_i && (haddr[1:0] != 2'b00) |=> err_first);          // R6
   AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      start && (int'(haddr[ADDR_W-1:2]) >= NUM_REGS) |=> err_first);         // R7
   AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      err_first |=> hresp && hreadyout);                                     // R8
   AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      err_first |=> $stable(ctrl_en_o) && $stable(scratch_o));               // R4
   AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> !hresp && hreadyout);                                        // R9
   AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> ##1 ($stable(ctrl_en_o) && $stable(scratch_o)));             // R9
   AST_OKAY_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !hresp |-> hreadyout);                                                 // R10

endmodule

bind prs_reg_slave prs_checker #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .NUM_SCRATCH (NUM_SCRATCH)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .hsel        (hsel),
   .haddr       (haddr),
   .htrans      (htrans),
   .hsize       (hsize),
   .hprot       (hprot),
   .priv_only_i (priv_only_i),
   .align_chk_i (align_chk_i),
   .hreadyout   (hreadyout),
   .hresp       (hresp),
   .ctrl_en_o   (ctrl_en_o),
   .scratch_o   (scratch_o)
);

// File: tb/prs_reg_slave_tb_top.sv
module prs_reg_slave_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsel = 1'b0;
   logic [7:0]  haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'b010;
   logic [3:0]  hprot = 4'b0000;
   logic [31:0] hwdata = '0;
   logic        priv_only_i = 1'b0;
   logic        align_chk_i = 1'b0;
   logic [31:0] status_set_i = '0;
   logic [31:0] hrdata;
   logic        hreadyout, hresp;
   logic [31:0] ctrl_en_o, status_o;
   logic [63:0] scratch_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [31:0] m_ctrl = '0, m_stat = '0, m_s0 = '0, m_s1 = '0;

   always #10 clk = ~clk;

   prs_reg_slave dut_i (
      .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata),
      .priv_only_i(priv_only_i), .align_chk_i(align_chk_i),
      .status_set_i(status_set_i), .hrdata(hrdata), .hreadyout(hreadyout),
      .hresp(hresp), .ctrl_en_o(ctrl_en_o), .status_o(status_o),
      .scratch_o(scratch_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      chk(ctrl_en_o == m_ctrl, req, "enable reg", ctrl_en_o, m_ctrl);
      chk(status_o == m_stat, req, "status reg", status_o, m_stat);
      chk(scratch_o[31:0] == m_s0, req, "scratch0", scratch_o[31:0], m_s0);
      chk(scratch_o[63:32] == m_s1, req, "scratch1", scratch_o[63:32], m_s1);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // Non-pipelined transfer; returns at a falling edge after the write commits.
   task automatic xfer(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                       input logic [3:0] prot, input logic [31:0] wd,
                       output bit err, output logic [31:0] rd);
      @(negedge clk);
      hsel = 1'b1; htrans = 2'b10; hwrite = wr; haddr = a; hsize = sz; hprot = prot;
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hwdata = wd;
      err = hresp;
      rd  = hrdata;
      if (hresp) begin
         chk(!hreadyout, "R8", "first error cycle ready", 32'(hreadyout), 32'd0);
         @(negedge clk);
         chk(hresp && hreadyout, "R8", "second error cycle",
             {30'd0, hresp, hreadyout}, 32'd3);
         @(negedge clk);
         chk(!hresp && hreadyout, "R8", "okay after error",
             {30'd0, hresp, hreadyout}, 32'd1);
      end else begin
         chk(hreadyout, "R10", "okay without wait", 32'(hreadyout), 32'd1);
         @(negedge clk);
      end
   endtask

   task automatic pulse_evt(input logic [31:0] v);
      @(negedge clk);
      status_set_i = v;
      @(negedge clk);
      status_set_i = '0;
      m_stat = m_stat | v;
      chk(status_o == m_stat, "R3", "status set by event", status_o, m_stat);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
         $finish;
      end
   end

   initial begin
      bit          err, legal, mis;
      logic [31:0] rd, wd, exp_rd;
      int          idx, it;
      string       tag;
      it = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hreadyout, "R1", "reset hreadyout", 32'(hreadyout), 32'd1);
      chk(!hresp, "R1", "reset hresp", 32'(hresp), 32'd0);
      check_regs("R1");

      for (int po = 0; po < 2; po++) begin
         for (int ac = 0; ac < 2; ac++) begin
            for (int pb = 0; pb < 2; pb++) begin
               for (int sz = 0; sz < 4; sz++) begin
                  for (int a = 0; a < 24; a++) begin
                     it++;
                     priv_only_i = po[0];
                     align_chk_i = ac[0];
                     idx   = a / 4;
                     mis   = (a % 4) != 0;
                     legal = (sz == 2) && (pb == po) && !(ac == 1 && mis) && (idx < 4);
                     if (sz != 2)               tag = "R5";
                     else if (pb != po)         tag = "R4";
                     else if (ac == 1 && mis)   tag = "R6";
                     else if (idx >= 4)         tag = "R7";
                     else if (mis)              tag = "R6";
                     else if (idx == 1)         tag = "R3";
                     else                       tag = "R2";

                     pulse_evt(32'(it) * 32'h9E3779B9);
                     wd = (32'(it) * 32'h01000193) ^ 32'h5A5A_0F0F;

                     xfer(1'b1, 8'(a), 3'(sz), {2'b00, pb[0], 1'b1}, wd, err, rd);
                     chk(err == !legal, tag, "write response", 32'(err), 32'(!legal));
                     if (legal) begin
                        case (idx)
                           0: m_ctrl = wd;
                           1: m_stat = m_stat & ~wd;
                           2: m_s0   = wd;
                           default: m_s1 = wd;
                        endcase
                     end
                     check_regs(tag);

                     xfer(1'b0, 8'(a), 3'(sz), {2'b10, pb[0], 1'b0}, 32'hDEAD_BEEF, err, rd);
                     chk(err == !legal, tag, "read response", 32'(err), 32'(!legal));
                     if (legal) begin
                        case (idx)
                           0: exp_rd = m_ctrl;
                           1: exp_rd = m_stat;
                           2: exp_rd = m_s0;
                           default: exp_rd = m_s1;
                        endcase
                        chk(rd == exp_rd, tag, "read data", rd, exp_rd);
                     end
                     check_regs(tag);
                  end
               end
            end
         end
      end

      // R9: IDLE, BUSY and deselected NONSEQ writes to scratch0 have no effect.
      priv_only_i = 1'b0;
      align_chk_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         hsel   = (k != 2);
         htrans = (k == 2) ? 2'b10 : 2'(k);
         hwrite = 1'b1; haddr = 8'h08; hsize = 3'b010; hprot = 4'b0001;
         @(negedge clk);
         hsel = 1'b0; htrans = 2'b00; hwdata = 32'hCAFE_0000 + 32'(k);
         chk(!hresp && hreadyout, "R9", "idle/busy/unselected response",
             {30'd0, hresp, hreadyout}, 32'd1);
         @(negedge clk);
         check_regs("R9");
      end

      done = 1'b1;
      report();
      $finish;
   end

endmodule